// File: doc/BRIEF.md
# Affine Scanline Texture Coordinate Generator

This block produces one pair of integer texture coordinates per displayed pixel for a background layer that is rotated and scaled by a 2x2 matrix. When a line begins it captures the matrix entries, the rotation centre, the scroll position and the current line number. During the blanking interval that follows, it forms two fixed-point line bases with a single shared multiplier. Each bound is `a*clamp(sh-ch) + b*clamp(sv-cv) + b*y + ch*256` for the horizontal axis, and the same with `c` and `d` and `cv*256` for the vertical axis.

After that, every accepted pixel adds the constant `a` to the horizontal accumulator and `c` to the vertical one. The coordinates sent out are the integer parts of the two accumulators. No multiplication is done per pixel. The display pipeline pulses `line_start` once per line, waits for `coord_ready`, and then raises `pix_en` for each pixel it wants. The fetch stage takes the coordinates one cycle later, qualified by `coord_valid`.

Top module: `affine_coord_gen`

## Requirements
- R1: After reset `coord_ready` and `coord_valid` are 0, and `tex_x` and `tex_y` are 0.
- R2: If `line_start` is sampled high on clock edge T, `coord_ready` is 0 after edges T through T+7 and is 1 after edge T+8. It then stays 1 until the next `line_start`. No pixel is accepted while `coord_ready` is 0.
- R3: The first pixel of a line gives `tex_x = floor(PX/256)`, where PX = a*clamp(sh-ch) + b*clamp(sv-cv) + b*y + ch*256. The matrix entries are signed 8.8 values of 16 bits. The scroll and centre inputs are signed 13 bits. The line number is unsigned 8 bits.
- R4: The first pixel of a line gives `tex_y = floor(PY/256)`, where PY = c*clamp(sh-ch) + d*clamp(sv-cv) + d*y + cv*256.
- R5: clamp() limits each difference to the signed 10-bit range [-512, 511] before it is multiplied.
- R6: The n-th accepted pixel of a line (n from 0) gives `tex_x = floor((PX + n*a)/256)` and `tex_y = floor((PY + n*c)/256)`. Division rounds toward minus infinity.
- R7: The values are captured on the edge that samples `line_start`. Changes to any register input after that edge have no effect on the coordinates of that line.
- R8: A cycle with `pix_en` low does not advance the line. On the next cycle `coord_valid` is 0 and `tex_x` and `tex_y` keep their values. When `pix_en` is high and `coord_ready` is low, the request is ignored.
- R9: A `line_start` in the middle of a line drops `coord_ready` and `coord_valid` on that edge and restarts the base computation with the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_start | input | 1 | One-cycle pulse that begins a line and captures the register inputs |
| pix_en | input | 1 | Request for the next pixel's coordinates |
| line_y | input | 8 | Current line number, unsigned |
| mat_a | input | 16 | Matrix entry a, signed 8.8 |
| mat_b | input | 16 | Matrix entry b, signed 8.8 |
| mat_c | input | 16 | Matrix entry c, signed 8.8 |
| mat_d | input | 16 | Matrix entry d, signed 8.8 |
| scroll_h | input | 13 | Horizontal scroll, signed |
| scroll_v | input | 13 | Vertical scroll, signed |
| ctr_h | input | 13 | Horizontal rotation centre, signed |
| ctr_v | input | 13 | Vertical rotation centre, signed |
| coord_ready | output | 1 | Line bases are loaded and pixels may be requested |
| coord_valid | output | 1 | `tex_x` and `tex_y` hold a new pixel's coordinates |
| tex_x | output | 21 | Integer horizontal texture coordinate, signed |
| tex_y | output | 21 | Integer vertical texture coordinate, signed |

## Verification
Random lines with scroll and centre values taken from the full 13-bit range push most differences into saturation. Lines with offsets kept within a few hundred of the centre exercise the products without clamping. Comparing the two kinds of line separates a fault in the clamp from a fault in the multiply-accumulate order.

Directed lines cover the following cases:
- The largest negative matrix entry, which checks rounding toward minus infinity.
- Line 255, which checks that the line number is taken as unsigned.
- Clamps at exactly 511 and -512.
- A zero matrix, where only the centre terms remain.

On each line the bench also scrambles every register input right after the capture edge. It inserts random idle cycles and early requests, and cuts lines short with a new `line_start`. Together these show capture timing, stepping only on accepted pixels, and restart behaviour.

// File: rtl/affine_coord_pkg.sv
// Package: shared definitions for the affine coordinate generator.
// Holds the order in which the shared multiplier forms the six line
// products and a helper that says which accumulator a product feeds.
package affine_coord_pkg;

    // Product schedule, one per cycle; first three feed X, last three feed Y.
    typedef enum logic [2:0] {
        PROD_A_DH = 3'd0,
        PROD_B_DV = 3'd1,
        PROD_B_LY = 3'd2,
        PROD_C_DH = 3'd3,
        PROD_D_DV = 3'd4,
        PROD_D_LY = 3'd5
    } prod_sel_e;

    localparam int unsigned PROD_COUNT = 6;

    // True when the selected product is summed into the horizontal base.
    function automatic logic feeds_x(input prod_sel_e sel);
        return (sel == PROD_A_DH) || (sel == PROD_B_DV) || (sel == PROD_B_LY);
    endfunction

endpackage

// File: rtl/affine_diff_clamp.sv
// Module: affine_diff_clamp
// Subtracts a centre from a position and saturates the signed difference
// to a CW-bit signed range. Purely combinational.
// Assumes IW >= CW so that saturation is reachable from both sides.
module affine_diff_clamp #(
    parameter int IW = 13,
    parameter int CW = 10
) (
    input  logic signed [IW-1:0] pos,
    input  logic signed [IW-1:0] ctr,
    output logic signed [CW-1:0] clamped
);
    localparam logic signed [IW:0] HI = (IW+1)'((2 ** (CW - 1)) - 1);
    localparam logic signed [IW:0] LO = -HI - (IW+1)'(1);

    logic signed [IW:0] diff;

    // Full-precision difference followed by two-sided saturation.
    always_comb begin
        diff = {pos[IW-1], pos} - {ctr[IW-1], ctr};
        if (diff > HI)
            clamped = HI[CW-1:0];
        else if (diff < LO)
            clamped = LO[CW-1:0];
        else
            clamped = diff[CW-1:0];
    end
endmodule

// File: rtl/affine_line_latch.sv
// Module: affine_line_latch
// Captures matrix entries, clamped offsets, centres and line number on the
// edge that samples line_start, and raises go one cycle later so the
// sequencer starts from stable captured values.
// Assumes line_start is a single-cycle pulse.
module affine_line_latch #(
    parameter int MW = 16,
    parameter int OW = 13,
    parameter int CW = 10,
    parameter int LW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_start,
    input  logic [LW-1:0]        line_y,
    input  logic signed [MW-1:0] mat_a,
    input  logic signed [MW-1:0] mat_b,
    input  logic signed [MW-1:0] mat_c,
    input  logic signed [MW-1:0] mat_d,
    input  logic signed [OW-1:0] scroll_h,
    input  logic signed [OW-1:0] scroll_v,
    input  logic signed [OW-1:0] ctr_h,
    input  logic signed [OW-1:0] ctr_v,
    output logic signed [MW-1:0] lat_a,
    output logic signed [MW-1:0] lat_b,
    output logic signed [MW-1:0] lat_c,
    output logic signed [MW-1:0] lat_d,
    output logic signed [CW-1:0] lat_dh,
    output logic signed [CW-1:0] lat_dv,
    output logic signed [OW-1:0] lat_ch,
    output logic signed [OW-1:0] lat_cv,
    output logic [LW-1:0]        lat_y,
    output logic                 go
);
    logic signed [OW-1:0] axis_pos [2];
    logic signed [OW-1:0] axis_ctr [2];
    logic signed [CW-1:0] axis_clp [2];

    assign axis_pos[0] = scroll_h;
    assign axis_pos[1] = scroll_v;
    assign axis_ctr[0] = ctr_h;
    assign axis_ctr[1] = ctr_v;

    // One clamp per screen axis.
    for (genvar g = 0; g < 2; g++) begin : g_axis
        affine_diff_clamp #(.IW(OW), .CW(CW)) i_clamp (
            .pos     (axis_pos[g]),
            .ctr     (axis_ctr[g]),
            .clamped (axis_clp[g])
        );
    end

    // Capture every line parameter at the line boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_a  <= '0;
            lat_b  <= '0;
            lat_c  <= '0;
            lat_d  <= '0;
            lat_dh <= '0;
            lat_dv <= '0;
            lat_ch <= '0;
            lat_cv <= '0;
            lat_y  <= '0;
        end else if (line_start) begin
            lat_a  <= mat_a;
            lat_b  <= mat_b;
            lat_c  <= mat_c;
            lat_d  <= mat_d;
            lat_dh <= axis_clp[0];
            lat_dv <= axis_clp[1];
            lat_ch <= ctr_h;
            lat_cv <= ctr_v;
            lat_y  <= line_y;
        end
    end

    // Delayed start pulse for the base sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            go <= 1'b0;
        else
            go <= line_start;
    end
endmodule

// File: rtl/affine_base_mac.sv
// Module: affine_base_mac
// Forms both line bases with one shared signed multiplier: preloads the
// centre terms, then adds one product per cycle in the package schedule.
// done pulses for one cycle when both sums are final.
// Assumes captured inputs stay stable from go until done.
module affine_base_mac
    import affine_coord_pkg::*;
#(
    parameter int MW   = 16,
    parameter int OW   = 13,
    parameter int CW   = 10,
    parameter int LW   = 8,
    parameter int OPW  = 10,
    parameter int ACCW = 29,
    parameter int FRAC = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   line_start,
    input  logic                   go,
    input  logic signed [MW-1:0]   lat_a,
    input  logic signed [MW-1:0]   lat_b,
    input  logic signed [MW-1:0]   lat_c,
    input  logic signed [MW-1:0]   lat_d,
    input  logic signed [CW-1:0]   lat_dh,
    input  logic signed [CW-1:0]   lat_dv,
    input  logic signed [OW-1:0]   lat_ch,
    input  logic signed [OW-1:0]   lat_cv,
    input  logic [LW-1:0]          lat_y,
    output logic signed [ACCW-1:0] base_x,
    output logic signed [ACCW-1:0] base_y,
    output logic                   busy,
    output logic                   done
);
    localparam int PW  = MW + OPW;
    localparam int CNW = 3;
    localparam logic [CNW-1:0] LAST = CNW'(PROD_COUNT - 1);

    logic [CNW-1:0]        step;
    prod_sel_e             sel;
    logic signed [MW-1:0]  op_m;
    logic signed [OPW-1:0] op_v;
    logic signed [PW-1:0]  prod;
    logic signed [ACCW-1:0] prod_ext;
    logic signed [OPW-1:0] dh_ext;
    logic signed [OPW-1:0] dv_ext;
    logic signed [OPW-1:0] y_ext;

    assign sel    = prod_sel_e'(step);
    assign dh_ext = OPW'(lat_dh);
    assign dv_ext = OPW'(lat_dv);
    assign y_ext  = {{(OPW - LW){1'b0}}, lat_y};

    // Operand selection for the shared multiplier.
    always_comb begin
        unique case (sel)
            PROD_A_DH: begin op_m = lat_a; op_v = dh_ext; end
            PROD_B_DV: begin op_m = lat_b; op_v = dv_ext; end
            PROD_B_LY: begin op_m = lat_b; op_v = y_ext;  end
            PROD_C_DH: begin op_m = lat_c; op_v = dh_ext; end
            PROD_D_DV: begin op_m = lat_d; op_v = dv_ext; end
            PROD_D_LY: begin op_m = lat_d; op_v = y_ext;  end
            default:   begin op_m = '0;    op_v = '0;     end
        endcase
    end

    // The single multiplier and its sign extension to accumulator width.
    assign prod     = op_m * op_v;
    assign prod_ext = {{(ACCW - PW){prod[PW-1]}}, prod};

    // Sequencer: preload centre terms, then one multiply-add per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_x <= '0;
            base_y <= '0;
            step   <= '0;
            busy   <= 1'b0;
            done   <= 1'b0;
        end else if (line_start) begin
            busy <= 1'b0;
            done <= 1'b0;
        end else if (go) begin
            base_x <= {{(ACCW - OW - FRAC){lat_ch[OW-1]}}, lat_ch, {FRAC{1'b0}}};
            base_y <= {{(ACCW - OW - FRAC){lat_cv[OW-1]}}, lat_cv, {FRAC{1'b0}}};
            step   <= '0;
            busy   <= 1'b1;
            done   <= 1'b0;
        end else if (busy) begin
            if (feeds_x(sel))
                base_x <= base_x + prod_ext;
            else
                base_y <= base_y + prod_ext;
            step <= step + 1'b1;
            if (step == LAST) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end else begin
            done <= 1'b0;
        end
    end
endmodule

// File: rtl/affine_pixel_step.sv
// Module: affine_pixel_step
// Loads the line bases into two accumulators, then per accepted pixel
// registers the integer parts and adds the step constants.
// Assumes step constants are stable for the whole line.
module affine_pixel_step #(
    parameter int MW   = 16,
    parameter int ACCW = 29,
    parameter int FRAC = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        line_start,
    input  logic                        load,
    input  logic                        pix_en,
    input  logic signed [ACCW-1:0]      base_x,
    input  logic signed [ACCW-1:0]      base_y,
    input  logic signed [MW-1:0]        step_x,
    input  logic signed [MW-1:0]        step_y,
    output logic                        ready,
    output logic                        valid,
    output logic signed [ACCW-FRAC-1:0] out_x,
    output logic signed [ACCW-FRAC-1:0] out_y
);
    logic signed [ACCW-1:0] acc_x;
    logic signed [ACCW-1:0] acc_y;
    logic signed [ACCW-1:0] inc_x;
    logic signed [ACCW-1:0] inc_y;

    assign inc_x = {{(ACCW - MW){step_x[MW-1]}}, step_x};
    assign inc_y = {{(ACCW - MW){step_y[MW-1]}}, step_y};

    // Accumulator load, per-pixel output and step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_x <= '0;
            acc_y <= '0;
            ready <= 1'b0;
            valid <= 1'b0;
            out_x <= '0;
            out_y <= '0;
        end else if (line_start) begin
            ready <= 1'b0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (load) begin
                acc_x <= base_x;
                acc_y <= base_y;
                ready <= 1'b1;
            end else if (ready && pix_en) begin
                out_x <= acc_x[ACCW-1:FRAC];
                out_y <= acc_y[ACCW-1:FRAC];
                valid <= 1'b1;
                acc_x <= acc_x + inc_x;
                acc_y <= acc_y + inc_y;
            end
        end
    end
endmodule

// File: rtl/affine_coord_gen.sv
// Module: affine_coord_gen (top)
// Rotation/scale texture coordinate generator: capture on line start,
// sequential base computation, then add-only per-pixel stepping.
// Assumes line_start is a one-cycle pulse and the line gap covers the
// base latency before pixels are needed.
module affine_coord_gen #(
    parameter int MW   = 16,
    parameter int OW   = 13,
    parameter int CW   = 10,
    parameter int LW   = 8,
    parameter int FRAC = 8,
    localparam int OPW  = (CW > LW + 1) ? CW : LW + 1,
    localparam int ACCW = MW + OPW + 3,
    localparam int TW   = ACCW - FRAC
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_start,
    input  logic                 pix_en,
    input  logic [LW-1:0]        line_y,
    input  logic signed [MW-1:0] mat_a,
    input  logic signed [MW-1:0] mat_b,
    input  logic signed [MW-1:0] mat_c,
    input  logic signed [MW-1:0] mat_d,
    input  logic signed [OW-1:0] scroll_h,
    input  logic signed [OW-1:0] scroll_v,
    input  logic signed [OW-1:0] ctr_h,
    input  logic signed [OW-1:0] ctr_v,
    output logic                 coord_ready,
    output logic                 coord_valid,
    output logic signed [TW-1:0] tex_x,
    output logic signed [TW-1:0] tex_y
);
    logic signed [MW-1:0]   lat_a, lat_b, lat_c, lat_d;
    logic signed [CW-1:0]   lat_dh, lat_dv;
    logic signed [OW-1:0]   lat_ch, lat_cv;
    logic [LW-1:0]          lat_y;
    logic                   go;
    logic signed [ACCW-1:0] base_x, base_y;
    logic                   mac_busy;
    logic                   mac_done;

    affine_line_latch #(.MW(MW), .OW(OW), .CW(CW), .LW(LW)) i_latch (
        .clk, .rst_n, .line_start, .line_y,
        .mat_a, .mat_b, .mat_c, .mat_d,
        .scroll_h, .scroll_v, .ctr_h, .ctr_v,
        .lat_a, .lat_b, .lat_c, .lat_d,
        .lat_dh, .lat_dv, .lat_ch, .lat_cv, .lat_y, .go
    );

    affine_base_mac #(
        .MW(MW), .OW(OW), .CW(CW), .LW(LW),
        .OPW(OPW), .ACCW(ACCW), .FRAC(FRAC)
    ) i_mac (
        .clk, .rst_n, .line_start, .go,
        .lat_a, .lat_b, .lat_c, .lat_d,
        .lat_dh, .lat_dv, .lat_ch, .lat_cv, .lat_y,
        .base_x, .base_y, .busy(mac_busy), .done(mac_done)
    );

    affine_pixel_step #(.MW(MW), .ACCW(ACCW), .FRAC(FRAC)) i_step (
        .clk, .rst_n, .line_start,
        .load   (mac_done),
        .pix_en,
        .base_x, .base_y,
        .step_x (lat_a),
        .step_y (lat_c),
        .ready  (coord_ready),
        .valid  (coord_valid),
        .out_x  (tex_x),
        .out_y  (tex_y)
    );
endmodule

// File: rtl/affine_coord_chk.sv
// Module: affine_coord_chk
// Protocol checks for affine_coord_gen, attached by bind below.
module affine_coord_chk #(
    parameter int TW = 21
) (
    input logic          clk,
    input logic          rst_n,
    input logic          line_start,
    input logic          pix_en,
    input logic          coord_ready,
    input logic          coord_valid,
    input logic [TW-1:0] tex_x,
    input logic [TW-1:0] tex_y,
    input logic          mac_busy
);
    // R9: a new line drops readiness on the following cycle.
    p_ready_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> !coord_ready);

    // R2: ready persists until the next line start.
    p_ready_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (coord_ready && !line_start) |=> coord_ready);

    // R2: a pixel is produced only for a request made while ready.
    p_no_early_pixel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        coord_valid |-> ($past(coord_ready) && $past(pix_en)));

    // R8: an idle cycle neither emits nor moves the coordinates.
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> (!coord_valid && $stable(tex_x) && $stable(tex_y)));

    // R2: the multiplier is never busy while pixels are being served.
    p_busy_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mac_busy, coord_ready}));
endmodule

bind affine_coord_gen affine_coord_chk #(.TW(TW)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_start  (line_start),
    .pix_en      (pix_en),
    .coord_ready (coord_ready),
    .coord_valid (coord_valid),
    .tex_x       (tex_x),
    .tex_y       (tex_y),
    .mac_busy    (mac_busy)
);

// File: tb/test_affine_coord_gen.sv
// Bench for affine_coord_gen: seeded random lines plus directed corners,
// each pixel compared with a direct evaluation of the line formula.
module test_affine_coord_gen;
    localparam int TW = 21;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_start = 1'b0;
    logic pix_en = 1'b0;
    logic [7:0] line_y = '0;
    logic signed [15:0] mat_a = '0, mat_b = '0, mat_c = '0, mat_d = '0;
    logic signed [12:0] scroll_h = '0, scroll_v = '0, ctr_h = '0, ctr_v = '0;
    logic coord_ready, coord_valid;
    logic signed [TW-1:0] tex_x, tex_y;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    affine_coord_gen i_affine_coord_gen (
        .clk, .rst_n, .line_start, .pix_en, .line_y,
        .mat_a, .mat_b, .mat_c, .mat_d,
        .scroll_h, .scroll_v, .ctr_h, .ctr_v,
        .coord_ready, .coord_valid, .tex_x, .tex_y
    );

    function automatic longint clampv(input longint v);
        if (v > 511) return 511;
        if (v < -512) return -512;
        return v;
    endfunction

    function automatic longint floor256(input longint v);
        return v >>> 8;
    endfunction

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic scramble();
        mat_a = 16'($urandom); mat_b = 16'($urandom);
        mat_c = 16'($urandom); mat_d = 16'($urandom);
        scroll_h = 13'($urandom); scroll_v = 13'($urandom);
        ctr_h = 13'($urandom); ctr_v = 13'($urandom);
        line_y = 8'($urandom);
    endtask

    // Runs one line with the current register inputs; npix accepted pixels.
    task automatic run_line(input int npix, input int gap_pct);
        longint a, b, c, d, dh, dv, px, py, lx, ly;
        a = mat_a; b = mat_b; c = mat_c; d = mat_d;
        dh = clampv(longint'(scroll_h) - longint'(ctr_h));
        dv = clampv(longint'(scroll_v) - longint'(ctr_v));
        px = a * dh + b * dv + b * longint'(line_y) + longint'(ctr_h) * 256;
        py = c * dh + d * dv + d * longint'(line_y) + longint'(ctr_v) * 256;
        line_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        line_start = 1'b0;
        scramble();            // R7: later writes must not reach this line
        pix_en = 1'b1;         // R8: early requests must be ignored
        check("R9", "ready after line start", longint'(coord_ready), 0);
        check("R9", "valid after line start", longint'(coord_valid), 0);
        for (int i = 1; i < 8; i++) begin
            @(posedge clk);
            @(negedge clk);
            check("R2", "ready during latency", longint'(coord_ready), 0);
            check("R8", "valid before ready", longint'(coord_valid), 0);
        end
        @(posedge clk);
        @(negedge clk);
        check("R2", "ready at latency end", longint'(coord_ready), 1);
        lx = 0; ly = 0;
        for (int n = 0; n < npix; n++) begin
            if (int'($urandom_range(99)) < gap_pct) begin
                pix_en = 1'b0;
                @(posedge clk);
                @(negedge clk);
                check("R8", "valid on idle", longint'(coord_valid), 0);
                if (n > 0) begin
                    check("R8", "tex_x hold", longint'(tex_x), lx);
                    check("R8", "tex_y hold", longint'(tex_y), ly);
                end
                pix_en = 1'b1;
            end
            @(posedge clk);
            @(negedge clk);
            lx = floor256(px + longint'(n) * a);
            ly = floor256(py + longint'(n) * c);
            check("R6", "valid on pixel", longint'(coord_valid), 1);
            check(n == 0 ? "R3" : "R6", "tex_x", longint'(tex_x), lx);
            check(n == 0 ? "R4" : "R6", "tex_y", longint'(tex_y), ly);
        end
        pix_en = 1'b0;
    endtask

    task automatic set_regs(input int a, b, c, d, sh, sv, ch, cv, y);
        mat_a = 16'(a); mat_b = 16'(b); mat_c = 16'(c); mat_d = 16'(d);
        scroll_h = 13'(sh); scroll_v = 13'(sv);
        ctr_h = 13'(ch); ctr_v = 13'(cv); line_y = 8'(y);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1", "ready after reset", longint'(coord_ready), 0);
        check("R1", "valid after reset", longint'(coord_valid), 0);
        check("R1", "tex_x after reset", longint'(tex_x), 0);
        check("R1", "tex_y after reset", longint'(tex_y), 0);

        // R5: clamp exactly at +511 and beyond, both axes.
        set_regs(256, 256, -256, 256, 511, 4095, 0, -4096, 0);
        run_line(4, 0);
        // R5: clamp exactly at -512 and beyond.
        set_regs(-256, 128, 64, -128, -512, -4096, 0, 4095, 10);
        run_line(4, 0);
        // R6: most negative step, floor rounding downward.
        set_regs(-32768, 32767, -32768, 32767, 3, -7, 1, 2, 255);
        run_line(20, 30);
        // R3/R4: zero matrix leaves only the centre terms.
        set_regs(0, 0, 0, 0, 100, -100, -4096, 4095, 77);
        run_line(6, 0);
        // R3/R4: fractional steps, line 255 treated as unsigned.
        set_regs(3, -5, 7, 129, 40, -40, 12, -12, 255);
        run_line(40, 20);

        for (int ln = 0; ln < 40; ln++) begin
            scramble();
            if (ln % 2 == 0) begin
                scroll_h = ctr_h + 13'($urandom_range(1200) - 600);
                scroll_v = ctr_v + 13'($urandom_range(1200) - 600);
            end
            run_line(int'($urandom_range(64, 8)), 25);  // R9: cut short
        end

        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule